// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master from a fast system clock. It drives SCL low through an open-drain request, releases it, and watches the real line so that a slow rising edge or a slave that holds the clock low is taken into account. The bit engine beside it receives two one-cycle phase strobes. One marks the start of each low phase, where data may change. The other marks the first cycle the line is seen high, which is the sample point.

Timing is set by a clock-control count together with a mode bit and a duty bit. Standard timing uses the same number of cycles for low and high. Fast timing stretches the low phase relative to the high phase. A rise-time value lets the cycles spent waiting for the line to rise count toward the high phase, so that a slow edge does not lengthen the bit. The input-clock frequency field is checked against the legal range for the selected mode. An illegal setting, or a zero count, holds the generator idle with SCL released and raises an error flag.

The control path is a four-state machine. The states are IDLE, DRIVE_LOW, WAIT_RISE and HOLD_HIGH. The transitions are START (IDLE to DRIVE_LOW), LOW_DONE (DRIVE_LOW to WAIT_RISE), SEEN_HIGH (WAIT_RISE to HOLD_HIGH), HIGH_DONE (HOLD_HIGH to DRIVE_LOW) and ABORT (any state to IDLE when the enable is low or the configuration is illegal).

Top module: `scl_timebase`

## Requirements
- R1: After reset, and in the cycle after `enable` is sampled low, `scl_drive_low`, `fall_stb`, `high_stb` and `cfg_err` are 0. Raising `enable` again starts a fresh low phase whose length counts from zero.
- R2: With `fast_mode`=0 and the line rising at once, SCL is driven low for `ccr_cnt` clock cycles and released for `ccr_cnt` cycles.
- R3: With `fast_mode`=1 and `duty_sel`=0, SCL is driven low for 2×`ccr_cnt` cycles and released for `ccr_cnt` cycles.
- R4: With `fast_mode`=1 and `duty_sel`=1, SCL is driven low for 16×`ccr_cnt` cycles and released for 9×`ccr_cnt` cycles.
- R5: `cfg_err` is 1, one cycle after sampling, whenever `enable`=1 and one of these holds: `clk_mhz` is outside 2..46 with `fast_mode`=0, `clk_mhz` is outside 6..46 with `fast_mode`=1, or `ccr_cnt`=0. While `cfg_err` is 1, SCL stays released. This also applies when the setting turns illegal during a transfer.
- R6: The line rises d cycles after release, and H is the release length from R2–R4. If d+1 ≤ `rise_max`, the release lasts H cycles. If d+1 > `rise_max`, it lasts H + (d+1−`rise_max`) cycles.
- R7: An external low on SCL during the high phase freezes the high count. Each cycle of such stretching adds one cycle to the release.
- R8: `fall_stb` is high for exactly the first cycle of every low phase. `high_stb` is high for one cycle, d+1 cycles after release, where d is the rise delay of R6. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low clears counters and releases SCL |
| fast_mode | input | 1 | 0: standard timing, 1: fast timing |
| duty_sel | input | 1 | Fast-mode low/high ratio: 0 → 2:1, 1 → 16:9 |
| clk_mhz | input | 6 | Input clock frequency in MHz |
| ccr_cnt | input | 12 | Clock-control count in input clock cycles |
| rise_max | input | 6 | Maximum SCL rise time in input cycles, plus one |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 requests the pad to pull SCL low |
| fall_stb | output | 1 | First cycle of a low phase |
| high_stb | output | 1 | First cycle after SCL observed high |
| cfg_err | output | 1 | Illegal frequency or zero count while enabled |

## Verification
The assertions assume that `scl_in` is already synchronous to `clk` and free of glitches. They also assume it can be high only while the block is not pulling the line low. The configuration inputs are taken to change only while the generator is disabled, except when an illegal value is applied on purpose. The bench models the open-drain line as a wired AND of the block's release, a programmable rise delay and a programmable stretch window, all counted in whole clock cycles. It changes configuration only with the enable low, apart from the single mid-transfer error case.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_DRIVE_LOW = 2'd1,
        PH_WAIT_RISE = 2'd2,
        PH_HOLD_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_cfg_check.sv
module scl_cfg_check #(
    parameter int MHZ_W        = 6,
    parameter int CCR_W        = 12,
    parameter int MIN_STD_MHZ  = 2,
    parameter int MIN_FAST_MHZ = 6,
    parameter int MAX_MHZ      = 46
) (
    input  logic [MHZ_W-1:0] clk_mhz,
    input  logic             fast_mode,
    input  logic [CCR_W-1:0] ccr_cnt,
    output logic             cfg_ok
);
    localparam logic [MHZ_W-1:0] LO_STD  = MHZ_W'(MIN_STD_MHZ);
    localparam logic [MHZ_W-1:0] LO_FAST = MHZ_W'(MIN_FAST_MHZ);
    localparam logic [MHZ_W-1:0] HI_ANY  = MHZ_W'(MAX_MHZ);

    logic [MHZ_W-1:0] floor_mhz;

    always_comb begin
        floor_mhz = fast_mode ? LO_FAST : LO_STD;
        cfg_ok    = (clk_mhz >= floor_mhz) && (clk_mhz <= HI_ANY) && (ccr_cnt != '0);
    end
endmodule

// File: rtl/scl_period_calc.sv
module scl_period_calc #(
    parameter int CCR_W = 12,
    parameter int CNT_W = CCR_W + 5
) (
    input  logic [CCR_W-1:0] ccr_cnt,
    input  logic             fast_mode,
    input  logic             duty_sel,
    output logic [CNT_W-1:0] low_ticks,
    output logic [CNT_W-1:0] high_ticks
);
    logic [CNT_W-1:0] base;

    always_comb begin
        base = CNT_W'(ccr_cnt);
        if (!fast_mode) begin
            low_ticks  = base;
            high_ticks = base;
        end else if (!duty_sel) begin
            low_ticks  = base << 1;
            high_ticks = base;
        end else begin
            low_ticks  = base << 4;
            high_ticks = (base << 3) + base;
        end
    end
endmodule

// File: rtl/scl_rise_credit.sv
module scl_rise_credit #(
    parameter int TRISE_W = 6,
    parameter int CNT_W   = 17
) (
    input  logic [CNT_W-1:0]   rise_elapsed,
    input  logic [TRISE_W-1:0] rise_max,
    output logic [CNT_W-1:0]   credit
);
    logic [CNT_W-1:0] spent;
    logic [CNT_W-1:0] cap;

    always_comb begin
        spent  = rise_elapsed + CNT_W'(1);
        cap    = CNT_W'(rise_max);
        credit = (spent < cap) ? spent : cap;
    end
endmodule

// File: rtl/scl_timebase.sv
module scl_timebase #(
    parameter int MHZ_W        = 6,
    parameter int CCR_W        = 12,
    parameter int TRISE_W      = 6,
    parameter int MIN_STD_MHZ  = 2,
    parameter int MIN_FAST_MHZ = 6,
    parameter int MAX_MHZ      = 46
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               fast_mode,
    input  logic               duty_sel,
    input  logic [MHZ_W-1:0]   clk_mhz,
    input  logic [CCR_W-1:0]   ccr_cnt,
    input  logic [TRISE_W-1:0] rise_max,
    input  logic               scl_in,
    output logic               scl_drive_low,
    output logic               fall_stb,
    output logic               high_stb,
    output logic               cfg_err
);
    import scl_pkg::*;

    localparam int CNT_W = CCR_W + 5;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    scl_phase_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] low_ticks, high_ticks, credit;
    logic             cfg_ok, run_ok;

    scl_cfg_check #(
        .MHZ_W(MHZ_W), .CCR_W(CCR_W), .MIN_STD_MHZ(MIN_STD_MHZ),
        .MIN_FAST_MHZ(MIN_FAST_MHZ), .MAX_MHZ(MAX_MHZ)
    ) i_cfg (
        .clk_mhz(clk_mhz), .fast_mode(fast_mode), .ccr_cnt(ccr_cnt), .cfg_ok(cfg_ok)
    );

    scl_period_calc #(.CCR_W(CCR_W), .CNT_W(CNT_W)) i_period (
        .ccr_cnt(ccr_cnt), .fast_mode(fast_mode), .duty_sel(duty_sel),
        .low_ticks(low_ticks), .high_ticks(high_ticks)
    );

    scl_rise_credit #(.TRISE_W(TRISE_W), .CNT_W(CNT_W)) i_credit (
        .rise_elapsed(cnt_q), .rise_max(rise_max), .credit(credit)
    );

    assign run_ok = enable && cfg_ok;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!run_ok) begin
            state_d = PH_IDLE;                          // ABORT
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d = PH_DRIVE_LOW;             // START
                    cnt_d   = '0;
                end
                PH_DRIVE_LOW: begin
                    if (cnt_q >= low_ticks - ONE) begin
                        state_d = PH_WAIT_RISE;         // LOW_DONE
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                PH_WAIT_RISE: begin
                    if (scl_in) begin
                        state_d = PH_HOLD_HIGH;         // SEEN_HIGH
                        cnt_d   = credit;
                    end else if (cnt_q != '1) begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                PH_HOLD_HIGH: begin
                    if (!scl_in) begin
                        cnt_d = cnt_q;                  // stretched: freeze
                    end else if (cnt_q >= high_ticks - ONE) begin
                        state_d = PH_DRIVE_LOW;         // HIGH_DONE
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_drive_low <= 1'b0;
            fall_stb      <= 1'b0;
            high_stb      <= 1'b0;
            cfg_err       <= 1'b0;
        end else begin
            scl_drive_low <= (state_d == PH_DRIVE_LOW);
            fall_stb      <= (state_d == PH_DRIVE_LOW) && (state_q != PH_DRIVE_LOW);
            high_stb      <= (state_d == PH_HOLD_HIGH) && (state_q == PH_WAIT_RISE);
            cfg_err       <= enable && !cfg_ok;
        end
    end
endmodule

// File: rtl/scl_timebase_chk.sv
module scl_timebase_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic scl_drive_low,
    input logic fall_stb,
    input logic high_stb,
    input logic cfg_err
);
    AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low);                                  // R1
    AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !scl_drive_low);                                  // R5
    AST_HIGH_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        high_stb |-> ($past(scl_in) && !scl_drive_low));              // R6
    AST_LOW_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> fall_stb);                           // R8
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && high_stb));                                     // R8
    AST_FALL_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_drive_low);                                  // R8
endmodule

bind scl_timebase scl_timebase_chk i_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .fall_stb(fall_stb),
    .high_stb(high_stb), .cfg_err(cfg_err)
);

// File: tb/test_scl_timebase.sv
`timescale 1ns/1ps
module test_scl_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        fast_mode = 1'b0;
    logic        duty_sel = 1'b0;
    logic [5:0]  clk_mhz = 6'd8;
    logic [11:0] ccr_cnt = 12'd10;
    logic [5:0]  rise_max = 6'd3;
    logic        scl_in;
    logic        scl_drive_low, fall_stb, high_stb, cfg_err;

    int rise_dly = 0;
    int st_from  = 1000000;
    int st_len   = 0;
    int rel_cnt  = 0;
    int vectors  = 0;
    int miscmp   = 0;

    always #2 clk = ~clk;

    // open-drain line model: release, rise delay, external stretch window
    always @(posedge clk) begin
        if (scl_drive_low) rel_cnt <= 0;
        else               rel_cnt <= rel_cnt + 1;
    end
    assign scl_in = !scl_drive_low && (rel_cnt >= rise_dly)
                    && !((rel_cnt >= st_from) && (rel_cnt < st_from + st_len));

    scl_timebase i_scl_timebase (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
        .duty_sel(duty_sel), .clk_mhz(clk_mhz), .ccr_cnt(ccr_cnt),
        .rise_max(rise_max), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .fall_stb(fall_stb), .high_stb(high_stb), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic fm, input logic dt, input int mhz,
                         input int ccr, input int tr, input int d);
        @(negedge clk);
        enable = 1'b0;
        fast_mode = fm; duty_sel = dt;
        clk_mhz = 6'(mhz); ccr_cnt = 12'(ccr); rise_max = 6'(tr);
        rise_dly = d; st_from = 1000000; st_len = 0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic measure(output int lo, output int hi, output int hs_idx, output int fall_ok);
        int guard = 0;
        hs_idx = -1;
        @(negedge clk);
        while (!fall_stb && guard < 3000) begin @(negedge clk); guard++; end
        fall_ok = int'(scl_drive_low);
        lo = 0;
        while (scl_drive_low && guard < 3000) begin
            if (lo > 0 && fall_stb) fall_ok = 0;
            lo++; guard++; @(negedge clk);
        end
        hi = 0;
        while (!scl_drive_low && guard < 3000) begin
            if (high_stb && hs_idx < 0) hs_idx = hi;
            hi++; guard++; @(negedge clk);
        end
        if (guard >= 3000) chk("measure timeout", guard, 0);
    endtask

    task automatic t_reset;
        chk("R1 reset drive", int'(scl_drive_low), 0);
        chk("R1 reset fall_stb", int'(fall_stb), 0);
        chk("R1 reset high_stb", int'(high_stb), 0);
        chk("R1 reset cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_mode(input string req, input logic fm, input logic dt,
                          input int ccr, input int elo, input int ehi);
        int lo, hi, hs, fo;
        setup(fm, dt, 8, ccr, 3, 0);
        measure(lo, hi, hs, fo);
        measure(lo, hi, hs, fo);
        chk({req, " low"}, lo, elo);
        chk({req, " high"}, hi, ehi);
    endtask

    task automatic t_strobes;
        int lo, hi, hs, fo;
        setup(1'b0, 1'b0, 8, 10, 3, 0);
        measure(lo, hi, hs, fo);
        chk("R8 fall strobe on first low cycle only", fo, 1);
        chk("R8 high strobe index", hs, 1);
    endtask

    task automatic t_rise(input int d, input int ehi);
        int lo, hi, hs, fo;
        setup(1'b0, 1'b0, 8, 10, 5, d);
        measure(lo, hi, hs, fo);
        chk("R6 release length", hi, ehi);
        chk("R8 high strobe after rise", hs, d + 1);
    endtask

    task automatic t_stretch;
        int lo, hi, hs, fo;
        setup(1'b0, 1'b0, 8, 10, 3, 0);
        st_from = 3; st_len = 5;
        measure(lo, hi, hs, fo);
        chk("R7 stretched release", hi, 15);
        chk("R7 low unaffected", lo, 10);
    endtask

    task automatic t_cfg(input logic fm, input int mhz, input int ccr, input int eerr);
        int lows = 0;
        setup(fm, 1'b0, mhz, ccr, 3, 0);
        repeat (2) @(negedge clk);
        chk($sformatf("R5 cfg_err fm=%0d mhz=%0d ccr=%0d", fm, mhz, ccr), int'(cfg_err), eerr);
        if (eerr == 1) begin
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (scl_drive_low) lows++;
            end
            chk("R5 released while in error", lows, 0);
        end
    endtask

    task automatic t_mid_error;
        setup(1'b0, 1'b0, 8, 10, 3, 0);
        @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        clk_mhz = 6'd50;
        @(negedge clk);
        chk("R5 mid-run error flag", int'(cfg_err), 1);
        chk("R5 mid-run release", int'(scl_drive_low), 0);
    endtask

    task automatic t_disable;
        int lo, hi, hs, fo;
        setup(1'b0, 1'b0, 8, 10, 3, 0);
        @(negedge clk);
        while (!fall_stb) @(negedge clk);
        repeat (4) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 disable releases", int'(scl_drive_low), 0);
        chk("R1 disable clears flag", int'(cfg_err), 0);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        measure(lo, hi, hs, fo);
        chk("R1 fresh low after re-enable", lo, 10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode("R2 standard", 1'b0, 1'b0, 10, 10, 10);
        t_mode("R3 fast 2:1", 1'b1, 1'b0, 4, 8, 4);
        t_mode("R4 fast 16:9", 1'b1, 1'b1, 2, 32, 18);
        t_strobes();
        t_rise(2, 10);
        t_rise(4, 10);
        t_rise(7, 13);
        t_stretch();
        t_cfg(1'b0, 1, 10, 1);
        t_cfg(1'b0, 2, 10, 0);
        t_cfg(1'b0, 46, 10, 0);
        t_cfg(1'b0, 47, 10, 1);
        t_cfg(1'b1, 5, 10, 1);
        t_cfg(1'b1, 6, 10, 0);
        t_cfg(1'b0, 8, 0, 1);
        t_mid_error();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule